// File: doc/BRIEF.md
# ROM-Driven Square-Wave Melody Sequencer

The block plays a tune stored as one command byte per entry in an external melody ROM. On every cycle in which the melody tick input is high, it decodes the command at the current ROM address. The command is a rest, a stop marker or a note. A note produces a square wave on a single registered output pin. The waveform is built from four phases. Each phase lasts a number of ticks that depends on the note code and on the phase, and the octave flag can double that count. Phases 1 and 3 drive the pin high and phases 0 and 2 drive it low.

The length of each ROM entry comes from a step counter. That counter advances on ticks where the low seven bits of a shared free-running divider are all zero. When the step counter wraps, the ROM address moves to the next entry. The CPU controls the block through a two-bit control/status register. Bit 0 is the output enable. Bit 1 is a sticky flag that is set when a stop command is decoded. The CPU sets or clears the enable through a write port, and the same write can clear the stop flag.

The ROM read port is combinational: the block presents an address and uses the returned byte in the same cycle. No interface on this block carries a data stream, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level or strobe sampled on the rising clock edge.

Top module: `melody_seq`

## Requirements
- R1: After reset, `tone_out` is 0, `rom_addr` is 0 and `ctl_status` is 2'b00. The phase, cycle counter and step counter are cleared.
- R2: Only bits [5:0] of a ROM word are used. Bits [3:0] are the note code, bit 4 is the octave flag and bit 5 is the length flag. Bits [7:6] have no effect.
- R3: On a tick where the note code is 0, 14 or 15, `tone_out` becomes 0, the phase does not advance and the stop flag is not set.
- R4: On a tick where the note code is 1, `ctl_status[1]` becomes 1 on that edge and `tone_out` becomes 0.
- R5: On a tick with a tone code (2..13), the cycle counter increments. When the counter reaches the threshold, it clears and the phase advances 0→1→2→3→0. With the octave flag set to 1, the threshold for each phase comes from this per-code table (codes 2..13): phase0 = 7,8,8,9,9,10,11,11,12,13,14,14; phase1 = 8,8,9,9,10,11,11,12,13,13,14,15; phase2 = 8,8,9,9,10,10,11,12,12,13,14,15; phase3 = 8,9,9,10,10,11,11,12,13,14,14,15.
- R6: With the octave flag set to 0, every threshold is twice the table value.
- R7: On a tick with a tone code, `tone_out` takes phase bit 0 AND `ctl_status[0]`, using the phase held before that edge. On cycles without a tick, `tone_out` holds its value.
- R8: On a tick where `div_val[6:0]` is all zero, the step counter becomes (step+1) masked to 5 bits if the length flag is 1, or to 4 bits otherwise. `rom_addr` increments when the new step value is 0. `rom_addr` is 8 bits and wraps from 255 to 0.
- R9: A cycle with `ctl_wr` high loads `ctl_status[0]` from `ctl_wdata[0]`. If `ctl_wdata[1]` is also 1, the stop flag is cleared. If a stop command sets the flag in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Melody clock tick, one cycle per tick |
| div_val | input | 8 | Shared free-running divider value |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 2 | Bit 0: enable value; bit 1: 1 clears stop flag |
| ctl_status | output | 2 | Bit 0: enable; bit 1: stop flag |
| rom_addr | output | 8 | Melody ROM address |
| rom_data | input | 8 | Melody ROM word at `rom_addr` (same cycle) |
| tone_out | output | 1 | Registered tone output pin |

## Verification
Every result lands on the rising edge that samples the tick or the write. These are the new `tone_out` value, the phase and counter update, the step and address change, and any enable or stop-flag update. Each result is therefore visible one clock after the inputs are presented, and nothing depends on a later edge.

The bench drives all inputs at the falling edge and checks outputs 1 ns after the next rising edge. At each edge it advances a bench model from the pre-edge state and the same inputs, then compares `tone_out`, `rom_addr` and `ctl_status` every cycle. Directed runs measure the high time of one phase at both octaves and count the exact tick at which the address moves and then wraps.

// File: rtl/melody_pkg.sv
package melody_pkg;

  localparam int unsigned NOTE_W  = 4;
  localparam int unsigned PHASE_W = 2;
  localparam logic [NOTE_W-1:0] CODE_STOP  = 4'd1;
  localparam logic [NOTE_W-1:0] CODE_FIRST = 4'd2;
  localparam logic [NOTE_W-1:0] CODE_LAST  = 4'd13;

  typedef struct packed {
    logic              len_long;
    logic              oct_high;
    logic [NOTE_W-1:0] note;
  } mel_cmd_t;

  // Packed rows of 4-bit cycle counts, code 2 at the least significant nibble.
  localparam logic [47:0] PH0_CYC = {4'd14,4'd14,4'd13,4'd12,4'd11,4'd11,4'd10,4'd9,4'd9,4'd8,4'd8,4'd7};
  localparam logic [47:0] PH1_CYC = {4'd15,4'd14,4'd13,4'd13,4'd12,4'd11,4'd11,4'd10,4'd9,4'd9,4'd8,4'd8};
  localparam logic [47:0] PH2_CYC = {4'd15,4'd14,4'd13,4'd12,4'd12,4'd11,4'd10,4'd10,4'd9,4'd9,4'd8,4'd8};
  localparam logic [47:0] PH3_CYC = {4'd15,4'd14,4'd14,4'd13,4'd12,4'd11,4'd11,4'd10,4'd10,4'd9,4'd9,4'd8};

  function automatic logic note_is_tone(input logic [NOTE_W-1:0] n);
    return (n >= CODE_FIRST) && (n <= CODE_LAST);
  endfunction

  function automatic logic [3:0] phase_cycles(input logic [PHASE_W-1:0] ph,
                                              input logic [NOTE_W-1:0] n);
    logic [3:0]  col;
    logic [47:0] row;
    col = n - CODE_FIRST;
    case (ph)
      2'd0:    row = PH0_CYC;
      2'd1:    row = PH1_CYC;
      2'd2:    row = PH2_CYC;
      default: row = PH3_CYC;
    endcase
    if (!note_is_tone(n)) return 4'd0;
    return row[{col, 2'b00} +: 4];
  endfunction

endpackage

// File: rtl/melody_ctrl.sv
module melody_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_wdata,
  input  logic       set_stop,
  output logic       enable,
  output logic       stop_flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable    <= 1'b0;
      stop_flag <= 1'b0;
    end else begin
      if (ctl_wr) begin
        enable <= ctl_wdata[0];
        if (ctl_wdata[1]) stop_flag <= 1'b0;
      end
      if (set_stop) stop_flag <= 1'b1;
    end
  end

  assert_stop_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_stop |=> stop_flag);

  assert_stop_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[1] && !set_stop) |=> !stop_flag);

  assert_enable_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(enable));

endmodule

// File: rtl/melody_tone.sv
module melody_tone
  import melody_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic [NOTE_W-1:0] note,
  input  logic              oct_high,
  output logic              tone_q
);

  logic [PHASE_W-1:0] phase;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cnt_inc;
  logic [CNT_W-1:0]   thresh;
  logic [3:0]         base;
  logic               is_tone;

  always_comb begin
    is_tone = note_is_tone(note);
    base    = phase_cycles(phase, note);
    thresh  = oct_high ? CNT_W'({1'b0, base}) : CNT_W'({base, 1'b0});
    cnt_inc = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      cnt    <= '0;
      tone_q <= 1'b0;
    end else if (tick) begin
      if (is_tone) begin
        tone_q <= phase[0] & enable;
        if (cnt_inc >= thresh) begin
          cnt   <= '0;
          phase <= phase + PHASE_W'(1);
        end else begin
          cnt <= cnt_inc;
        end
      end else begin
        tone_q <= 1'b0;
      end
    end
  end

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tone_q));

  assert_muted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !enable) |=> !tone_q);

  assert_rest_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !is_tone) |=> ($stable(phase) && !tone_q));

  assert_phase_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase == $past(phase) || phase == $past(phase) + PHASE_W'(1)));

endmodule

// File: rtl/melody_step.sv
module melody_step #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned TB_BITS = 7,
  parameter int unsigned STEP_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              len_long,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [STEP_W-1:0] MASK_LONG  = '1;
  localparam logic [STEP_W-1:0] MASK_SHORT = MASK_LONG >> 1;

  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] step_nxt;
  logic              tb_hit;
  logic [DIV_W-1:0]  div_unused;

  assign div_unused = div_val;
  assign tb_hit     = tick && (div_val[TB_BITS-1:0] == '0);
  assign step_nxt   = (step + STEP_W'(1)) & (len_long ? MASK_LONG : MASK_SHORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
      addr <= '0;
    end else if (tb_hit) begin
      step <= step_nxt;
      if (step_nxt == '0) addr <= addr + ADDR_W'(1);
    end
  end

  assert_addr_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (addr == $past(addr) || addr == $past(addr) + ADDR_W'(1)));

  assert_addr_tb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && (div_val[TB_BITS-1:0] == '0)) |=> $stable(addr));

endmodule

// File: rtl/melody_seq.sv
module melody_seq
  import melody_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned TB_BITS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_wdata,
  output logic [1:0]        ctl_status,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic              tone_out
);

  localparam int unsigned CMD_W = $bits(mel_cmd_t);

  mel_cmd_t          cmd;
  logic [DATA_W-1:0] rom_unused;
  logic              enable;
  logic              stop_flag;
  logic              set_stop;

  assign rom_unused = rom_data;
  assign cmd        = mel_cmd_t'(rom_data[CMD_W-1:0]);
  assign set_stop   = tick && (cmd.note == CODE_STOP);
  assign ctl_status = {stop_flag, enable};

  melody_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .set_stop  (set_stop),
    .enable    (enable),
    .stop_flag (stop_flag)
  );

  melody_tone #(.CNT_W(5)) u_tone (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .enable   (enable),
    .note     (cmd.note),
    .oct_high (cmd.oct_high),
    .tone_q   (tone_out)
  );

  melody_step #(
    .ADDR_W  (ADDR_W),
    .DIV_W   (DIV_W),
    .TB_BITS (TB_BITS),
    .STEP_W  (5)
  ) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .div_val  (div_val),
    .len_long (cmd.len_long),
    .addr     (rom_addr)
  );

  assert_stop_out_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_stop |=> !tone_out);

endmodule

// File: tb/melody_seq_test.sv
`timescale 1ns/1ps
module melody_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] div_val = 8'd1;
  logic       ctl_wr = 1'b0;
  logic [1:0] ctl_wdata = 2'b00;
  logic [1:0] ctl_status;
  logic [7:0] rom_addr;
  logic [7:0] rom_data;
  logic       tone_out;

  logic [7:0] brom [256];
  assign rom_data = brom[rom_addr];

  int errors = 0;
  int checks = 0;

  // bench model state
  logic [7:0] m_addr;
  logic [4:0] m_step;
  logic [1:0] m_phase;
  int         m_cnt;
  logic       m_en, m_stop, m_out;

  always #5 clk = ~clk;

  melody_seq uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .div_val(div_val),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_status(ctl_status),
    .rom_addr(rom_addr), .rom_data(rom_data), .tone_out(tone_out)
  );

  function automatic int cyc_tab(input int ph, input int code);
    int r0[12] = '{7,8,8,9,9,10,11,11,12,13,14,14};
    int r1[12] = '{8,8,9,9,10,11,11,12,13,13,14,15};
    int r2[12] = '{8,8,9,9,10,10,11,12,12,13,14,15};
    int r3[12] = '{8,9,9,10,10,11,11,12,13,14,14,15};
    case (ph)
      0: return r0[code-2];
      1: return r1[code-2];
      2: return r2[code-2];
      default: return r3[code-2];
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; ctl_wr = 1'b0; div_val = 8'd1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_addr = 0; m_step = 0; m_phase = 0; m_cnt = 0;
    m_en = 0; m_stop = 0; m_out = 0;
  endtask

  task automatic cyc(input logic t, input logic [7:0] d, input logic w, input logic [1:0] wd);
    logic [7:0] word;
    int code, thr;
    logic sset;
    string ttag, stag;
    @(negedge clk);
    tick = t; div_val = d; ctl_wr = w; ctl_wdata = wd;
    word = brom[m_addr];
    code = int'(word[3:0]);
    sset = 1'b0;
    if (!t)                    ttag = "R7";
    else if (word[7:6] != 0)   ttag = "R2";
    else if (code == 1)        ttag = "R4";
    else if (code < 2 || code > 13) ttag = "R3";
    else if (word[4])          ttag = "R5";
    else                       ttag = "R6";
    stag = (t && code == 1) ? "R4" : "R9";
    if (t) begin
      if (code >= 2 && code <= 13) begin
        m_out = m_phase[0] & m_en;
        thr = cyc_tab(int'(m_phase), code) * (word[4] ? 1 : 2);
        m_cnt = m_cnt + 1;
        if (m_cnt >= thr) begin m_cnt = 0; m_phase = m_phase + 2'd1; end
      end else begin
        m_out = 1'b0;
        if (code == 1) sset = 1'b1;
      end
      if (d[6:0] == 7'd0) begin
        m_step = (m_step + 5'd1) & (word[5] ? 5'h1f : 5'h0f);
        if (m_step == 5'd0) m_addr = m_addr + 8'd1;
      end
    end
    if (w) begin
      m_en = wd[0];
      if (wd[1]) m_stop = 1'b0;
    end
    if (sset) m_stop = 1'b1;
    @(posedge clk); #1;
    check(ttag, int'(tone_out), int'(m_out));
    check("R8", int'(rom_addr), int'(m_addr));
    check(stag, int'(ctl_status), int'({m_stop, m_en}));
  endtask

  task automatic measure_high(input logic [7:0] word, input int exp, input string tag);
    int run; bit seen, done;
    for (int i = 0; i < 256; i++) brom[i] = word;
    do_reset();
    cyc(1'b0, 8'd1, 1'b1, 2'b01);
    run = 0; seen = 0; done = 0;
    for (int i = 0; i < 100; i++) begin
      cyc(1'b1, 8'd1, 1'b0, 2'b00);
      if (tone_out) begin seen = 1; if (!done) run++; end
      else if (seen) done = 1;
    end
    check(tag, run, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) brom[i] = 8'h00;
    do_reset();
    #1;
    check("R1", int'(tone_out), 0);
    check("R1", int'(rom_addr), 0);
    check("R1", int'(ctl_status), 0);

    // phase-1 high time: code 2, table value 8, doubled when octave flag is 0
    measure_high(8'h12, 8, "R5");
    measure_high(8'h02, 16, "R6");
    measure_high(8'hD2, 8, "R2");

    // muted tone: enable left low
    for (int i = 0; i < 256; i++) brom[i] = 8'h15;
    do_reset();
    for (int i = 0; i < 60; i++) cyc(1'b1, 8'd3, 1'b0, 2'b00);

    // stop set and clear, set wins on collision
    for (int i = 0; i < 256; i++) brom[i] = 8'h01;
    do_reset();
    cyc(1'b1, 8'd1, 1'b0, 2'b00);
    check("R4", int'(ctl_status[1]), 1);
    cyc(1'b0, 8'd1, 1'b1, 2'b11);
    check("R9", int'(ctl_status), 1);
    cyc(1'b1, 8'd1, 1'b1, 2'b10);
    check("R9", int'(ctl_status), 2);

    // address timing and wrap with short length
    for (int i = 0; i < 256; i++) brom[i] = (i % 3 == 0) ? 8'h0E : 8'h00;
    do_reset();
    for (int i = 0; i < 16; i++) cyc(1'b1, 8'd0, 1'b0, 2'b00);
    check("R8", int'(rom_addr), 1);
    for (int i = 16; i < 4096; i++) cyc(1'b1, 8'h80, 1'b0, 2'b00);
    check("R8", int'(rom_addr), 0);

    // random program and stimulus
    for (int i = 0; i < 256; i++) begin
      logic [7:0] w;
      w = 8'($urandom);
      if ($urandom % 4 != 0) w[7:6] = 2'b00;
      brom[i] = w;
    end
    do_reset();
    cyc(1'b0, 8'd1, 1'b1, 2'b01);
    for (int i = 0; i < 30000; i++) begin
      logic t, w; logic [7:0] d; logic [1:0] wd;
      t = ($urandom % 4) != 0;
      d = 8'($urandom);
      if ($urandom % 2 == 0) d[6:0] = 7'd0;
      w = ($urandom % 40) == 0;
      wd = 2'($urandom);
      if ($urandom % 4 != 0) wd[0] = 1'b1;
      cyc(t, d, w, wd);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule